// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-word burst access to a synchronous memory. A burst begins when one of two address strobes captures an external base address. After that, an advance input moves the two lowest address bits through a four-step sequence inside the aligned four-word block, while the upper bits keep the captured value. The ordering of the steps is chosen when the burst is loaded. With a low order select the steps count upward. With a high order select the steps follow an XOR pattern, which suits cache line fills that begin at the critical word.

Two strobes can start a burst. One belongs to the processor side and is qualified by a chip enable. The other belongs to the controller side and has no qualifier. When both strobes fire together, the processor strobe wins, and an output records which side owns the current burst. Bursting is never required: a fresh base address can be loaded on any cycle, in the middle of a burst or not. Holding advance low keeps the current address, so that wait states can be inserted. The memory array and the data path are outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, addrOut is all zeros, burstActive is 0 and procOwned is 0.
- R2: A load happens when procStrobe is 1 with chipEn 1, or when ctrlStrobe is 1. On the clock edge of a load, addrOut takes the value of addrIn, and burstActive becomes 1 and stays 1 until the next reset.
- R3: When both strobes load on the same edge, the processor strobe takes priority and procOwned becomes 1. A load by ctrlStrobe alone sets procOwned to 0. If procStrobe is 1 while chipEn is 0 and ctrlStrobe is 0, nothing happens: addrOut and procOwned keep their values.
- R4: With orderSel 0 captured at the load, each edge that has advance 1 and no load increments the low two address bits by one, modulo 4.
- R5: With orderSel 1 captured at the load, the low two address bits equal the starting low bits XOR a beat count. The beat count starts at 0 and increments modulo 4 on each advancing edge. orderSel is sampled only on the load edge.
- R6: After the fourth beat, the next advance returns the low bits to the starting value of the same four-word block. The upper address bits never change except on a load.
- R7: An edge with advance 0 and no load leaves addrOut unchanged.
- R8: A load takes precedence over advance on the same edge and restarts the sequence at the new base address.
- R9: Before the first load after reset, advance has no effect: addrOut stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| procStrobe | input | 1 | Processor-side address strobe, qualified by chipEn |
| ctrlStrobe | input | 1 | Controller-side address strobe |
| chipEn | input | 1 | Qualifies procStrobe |
| advance | input | 1 | Steps the burst by one beat |
| orderSel | input | 1 | 0 selects linear order, 1 selects interleaved order; captured at load |
| addrIn | input | ADDR_W | External base address |
| addrOut | output | ADDR_W | Address of the current beat |
| burstActive | output | 1 | A base address has been loaded since reset |
| procOwned | output | 1 | The current burst was started by the processor strobe |

## Verification
The bench builds the block with a 10-bit address and the default 2-bit beat field. The narrow upper field lets random base addresses repeat and cover every starting low-bit value in both orderings within a few thousand cycles. With a 2-bit beat field, every wrap from the fourth beat back to the first occurs often enough to be checked, both for each starting offset and for both strobe owners. Directed sequences cover the priority case, a chip-enable-masked strobe, wait states and a reload in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Strobes passed from the control module to the datapath each cycle
  typedef struct packed {
    logic load;      // capture the external base address
    logic stepBeat;  // advance the beat counter by one
    logic fromProc;  // the load comes from the processor-side strobe
  } burstCtl_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      procStrobe,
  input  logic      ctrlStrobe,
  input  logic      chipEn,
  input  logic      advance,
  output burstCtl_t ctl,
  output logic      burstActive,
  output logic      procOwned
);

  logic procLoad;
  logic anyLoad;

  // A processor strobe counts only while the chip is enabled; it wins over the controller strobe
  assign procLoad = procStrobe & chipEn;
  assign anyLoad  = procLoad | ctrlStrobe;

  always_comb begin
    ctl          = '0;
    ctl.load     = anyLoad;
    ctl.fromProc = procLoad;
    ctl.stepBeat = advance & burstActive & ~anyLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      procOwned   <= 1'b0;
    end else if (anyLoad) begin
      burstActive <= 1'b1;
      procOwned   <= procLoad;
    end
  end

  AST_PROC_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobe && chipEn && ctrlStrobe) |=> procOwned) else $error("priority"); // R3

  AST_MASKED_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobe && !chipEn && !ctrlStrobe) |=> $stable(procOwned)) else $error("mask"); // R3

  AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    burstActive |=> burstActive) else $error("sticky"); // R2

  AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !burstActive |-> !ctl.stepBeat) else $error("idle step"); // R9

endmodule

// File: rtl/burst_dpath.sv
module burst_dpath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstCtl_t         ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int UPPER_W = ADDR_W - BEAT_W;
  typedef logic [BEAT_W-1:0] lowT;

  logic [ADDR_W-1:0] baseAddr;
  lowT               beatCnt;
  logic              ordIlv;
  lowT               linLow;
  lowT               ilvLow;
  lowT               curLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      beatCnt  <= '0;
      ordIlv   <= 1'b0;
    end else if (ctl.load) begin
      baseAddr <= addrIn;
      beatCnt  <= '0;
      ordIlv   <= orderSel;
    end else if (ctl.stepBeat) begin
      beatCnt  <= beatCnt + lowT'(1);
    end
  end

  // Linear order: offset added to the start, wrapping inside the block
  assign linLow = lowT'(baseAddr[BEAT_W-1:0] + beatCnt);

  // Interleaved order: each low bit toggles with the matching beat-count bit
  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilvLow[b] = baseAddr[b] ^ beatCnt[b];
  end

  assign curLow  = ordIlv ? ilvLow : linLow;
  assign addrOut = {baseAddr[ADDR_W-1:BEAT_W], curLow};

  AST_LOAD_BASE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> addrOut == $past(addrIn)) else $error("load"); // R2

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepBeat && !ordIlv) |=>
      addrOut[BEAT_W-1:0] == lowT'($past(addrOut[BEAT_W-1:0]) + lowT'(1))) else $error("lin"); // R4

  AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepBeat && ordIlv) |=>
      lowT'(addrOut[BEAT_W-1:0] ^ baseAddr[BEAT_W-1:0]) ==
      lowT'($past(addrOut[BEAT_W-1:0] ^ baseAddr[BEAT_W-1:0]) + lowT'(1))) else $error("ilv"); // R5

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(addrOut[ADDR_W-1:BEAT_W])) else $error("upper"); // R6

  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.stepBeat) |=> $stable(addrOut)) else $error("hold"); // R7

  initial begin
    assert (UPPER_W >= 1) else $error("ADDR_W must exceed BEAT_W");
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              chipEn,
  input  logic              advance,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              burstActive,
  output logic              procOwned
);

  burstCtl_t ctl;

  burst_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .procStrobe (procStrobe),
    .ctrlStrobe (ctrlStrobe),
    .chipEn     (chipEn),
    .advance    (advance),
    .ctl        (ctl),
    .burstActive(burstActive),
    .procOwned  (procOwned)
  );

  burst_dpath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .addrIn  (addrIn),
    .orderSel(orderSel),
    .addrOut (addrOut)
  );

endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          procStrobe = 1'b0, ctrlStrobe = 1'b0, chipEn = 1'b0;
  logic          advance = 1'b0, orderSel = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] addrOut;
  logic          burstActive, procOwned;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [AW-1:0] mBase = '0;
  logic [BW-1:0] mBeat = '0;
  logic          mOrd = 1'b0, mAct = 1'b0, mProc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) dut_i (
    .clk(clk), .rstN(rstN), .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe),
    .chipEn(chipEn), .advance(advance), .orderSel(orderSel), .addrIn(addrIn),
    .addrOut(addrOut), .burstActive(burstActive), .procOwned(procOwned)
  );

  function automatic logic [AW-1:0] expAddr();
    logic [BW-1:0] low;
    low = mOrd ? (mBase[BW-1:0] ^ mBeat) : BW'(mBase[BW-1:0] + mBeat);
    return {mBase[AW-1:BW], low};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, reference update at posedge, compare at next negedge
  task automatic step(input logic ps, input logic cs, input logic ce,
                      input logic adv, input logic ord, input logic [AW-1:0] a,
                      input string req);
    logic pl, ld;
    procStrobe = ps; ctrlStrobe = cs; chipEn = ce; advance = adv; orderSel = ord; addrIn = a;
    @(posedge clk);
    pl = ps & ce;
    ld = pl | cs;
    if (ld) begin
      mBase = a; mBeat = '0; mOrd = ord; mAct = 1'b1; mProc = pl;
    end else if (adv && mAct) begin
      mBeat = mBeat + 1'b1;
    end
    @(negedge clk);
    check(req, addrOut, expAddr());
    check(req, AW'(burstActive), AW'(mAct));
    check(req, AW'(procOwned), AW'(mProc));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", addrOut, '0);
    check("R1", AW'(burstActive), '0);
    check("R1", AW'(procOwned), '0);
    rstN = 1'b1;
    @(negedge clk);
    // R9 advance before any load
    step(0, 0, 1, 1, 0, 10'h3a5, "R9");
    step(1, 0, 0, 1, 0, 10'h155, "R9");
    check("R9", addrOut, '0);
    // R2 load via controller strobe, linear from offset 2 -> R4, R6 wrap
    step(0, 1, 0, 0, 0, 10'h2b6, "R2");
    check("R2", addrOut, 10'h2b6);
    step(0, 0, 0, 1, 0, 10'h000, "R4");
    check("R4", addrOut, 10'h2b7);
    step(0, 0, 0, 1, 0, 10'h000, "R4");
    check("R4", addrOut, 10'h2b4);
    step(0, 0, 0, 1, 0, 10'h000, "R4");
    step(0, 0, 0, 1, 0, 10'h000, "R6");
    check("R6", addrOut, 10'h2b6);
    // R7 wait states
    step(0, 0, 0, 0, 1, 10'h3ff, "R7");
    step(0, 0, 0, 0, 0, 10'h3ff, "R7");
    check("R7", addrOut, 10'h2b6);
    // R3 both strobes, processor wins; R5 interleaved from offset 1
    step(1, 1, 1, 0, 1, 10'h1c1, "R3");
    check("R3", AW'(procOwned), 10'd1);
    step(0, 0, 0, 1, 0, 10'h000, "R5");
    check("R5", addrOut, 10'h1c0);
    step(0, 0, 0, 1, 0, 10'h000, "R5");
    check("R5", addrOut, 10'h1c3);
    step(0, 0, 0, 1, 0, 10'h000, "R5");
    check("R5", addrOut, 10'h1c2);
    step(0, 0, 0, 1, 0, 10'h000, "R6");
    check("R6", addrOut, 10'h1c1);
    // R3 masked processor strobe
    step(1, 0, 0, 0, 0, 10'h0f0, "R3");
    check("R3", addrOut, 10'h1c1);
    // R3 controller alone clears ownership
    step(0, 1, 1, 0, 0, 10'h044, "R3");
    check("R3", AW'(procOwned), 10'd0);
    // R8 reload with advance mid-burst
    step(0, 0, 0, 1, 0, 10'h000, "R8");
    step(1, 0, 1, 1, 1, 10'h23e, "R8");
    check("R8", addrOut, 10'h23e);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(($urandom % 6) == 0, ($urandom % 7) == 0, r[0] | r[1],
           ($urandom % 4) != 0, r[2], AW'($urandom), mOrd ? "R5" : "R4");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule